// File: doc/BRIEF.md
# Windowed Instruction Register File

This block keeps a small store of frequently used instruction words, split into several windows of equal size, of which exactly one is active at any time. A fetch stage reads the active window through a slot index. Program loading writes any entry of any window, named explicitly. The active window is chosen without dedicated save or restore instructions: the pointer rides inside function addresses.

On a call the pointer is taken from two bits of the call target, and those bits are cleared before the address is used for fetch. The caller's return address and its pointer go onto a small hardware link stack. A return pops that pair and restores both. One enable line per window is high only for the active window, so the other windows can sit in a low-power state. Functions with similar instruction mixes can share a window by carrying the same pointer bits.

Top module: `windowed_irf`

## Requirements
- R1: After reset the window pointer is 0, only enable bit 0 is high, both stack flags are 0, no redirect is valid, and every slot of every window reads as the no-operation word (default 32'h0) until it is written.
- R2: A call strobe loads the window pointer from target address bits [3:2]. Reads from the cycle after the strobe use the new window.
- R3: In the cycle after a call, redirect_valid is 1 and redirect_pc equals the call target with bits [3:2] cleared.
- R4: A call pushes the pair (call_link, window pointer before the call). A return with a non-empty stack pops the newest pair. In the next cycle the pointer equals the saved pointer, redirect_valid is 1 and redirect_pc equals the saved link address.
- R5: The stack holds 8 pairs. A call with 8 pairs already held drops the oldest pair, keeps the newest 8, and sets stack_overflow, which stays 1 until reset.
- R6: A return with an empty stack leaves the pointer unchanged, produces no redirect (redirect_valid 0 next cycle), and sets stack_underflow, which stays 1 until reset.
- R7: Exactly one bit of win_enable is 1 at all times, and its index equals win_ptr.
- R8: A write stores wr_insn at (wr_win, wr_slot) whatever the active window is. rd_insn combinationally returns the entry at rd_slot of the active window, so a write to another window does not change rd_insn.
- R9: When call and return strobes arrive in the same cycle, the call takes effect and the return is ignored: the stack is not popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_slot | input | 5 | Slot index into the active window |
| rd_insn | output | 32 | Instruction word at rd_slot of the active window |
| wr_en | input | 1 | Write strobe |
| wr_win | input | 2 | Window written |
| wr_slot | input | 5 | Slot written |
| wr_insn | input | 32 | Instruction word written |
| call_req | input | 1 | Call strobe |
| call_target | input | 32 | Call target address carrying the window pointer in bits [3:2] |
| call_link | input | 32 | Return address saved by the call |
| ret_req | input | 1 | Return strobe |
| redirect_valid | output | 1 | Fetch redirect present this cycle |
| redirect_pc | output | 32 | Fetch address of the redirect |
| win_ptr | output | 2 | Active window pointer |
| win_enable | output | 4 | One enable per window, high only for the active one |
| stack_overflow | output | 1 | Sticky: a call dropped the oldest stack pair |
| stack_underflow | output | 1 | Sticky: a return found the stack empty |

## Verification
The bench keeps the default build: four windows of 32 slots, 32-bit words and an 8-deep link stack. At this depth nine nested calls reach the overflow drop, and a short unwinding sequence reaches the empty-stack return. Random calls carry all four pointer values, so every enable line and every window's contents are exercised. Random writes land mostly in inactive windows, so the window isolation check comes up often.

// File: rtl/wirf_pkg.sv
package wirf_pkg;
  typedef enum logic [1:0] {
    FLOW_IDLE = 2'd0,
    FLOW_CALL = 2'd1,
    FLOW_RET  = 2'd2
  } flow_op_e;

  // Call has priority over return when both strobes are present.
  function automatic flow_op_e pick_flow(input logic call_s, input logic ret_s);
    if (call_s)     return FLOW_CALL;
    else if (ret_s) return FLOW_RET;
    else            return FLOW_IDLE;
  endfunction
endpackage

// File: rtl/wirf_window_bank.sv
module wirf_window_bank #(
  parameter int NWIN  = 4,
  parameter int NSLOT = 32,
  parameter int IW    = 32,
  parameter logic [IW-1:0] NOP_WORD = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(NWIN)-1:0]  wr_win,
  input  logic [$clog2(NSLOT)-1:0] wr_slot,
  input  logic [IW-1:0]            wr_data,
  input  logic [$clog2(NWIN)-1:0]  act_win,
  input  logic [$clog2(NSLOT)-1:0] rd_slot,
  output logic [IW-1:0]            rd_data,
  output logic [NWIN-1:0]          win_en
);
  localparam int PW      = $clog2(NWIN);
  localparam int SW      = $clog2(NSLOT);
  localparam int ENTRIES = NWIN * NSLOT;

  logic [IW-1:0]      store [ENTRIES];
  logic [ENTRIES-1:0] filled;

  logic [PW+SW-1:0] wr_idx, rd_idx;
  assign wr_idx = {wr_win, wr_slot};
  assign rd_idx = {act_win, rd_slot};

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     filled <= '0;
    else if (wr_en) filled[wr_idx] <= 1'b1;
  end

  assign rd_data = filled[rd_idx] ? store[rd_idx] : NOP_WORD;

  for (genvar g = 0; g < NWIN; g++) begin : g_en
    assign win_en[g] = (act_win == PW'(g));
  end
endmodule

// File: rtl/wirf_link_stack.sv
module wirf_link_stack #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int PW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_addr,
  input  logic [PW-1:0] push_ptr,
  output logic [AW-1:0] top_addr,
  output logic [PW-1:0] top_ptr,
  output logic          empty,
  output logic          full
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [AW-1:0]    addr_q [DEPTH];
  logic [PW-1:0]    ptr_q  [DEPTH];
  logic [IDX_W-1:0] head, head_up, head_dn;
  logic [CNT_W-1:0] count;

  function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(DEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  function automatic logic [IDX_W-1:0] wrap_dec(input logic [IDX_W-1:0] i);
    return (i == '0) ? IDX_W'(DEPTH - 1) : i - 1'b1;
  endfunction

  assign head_up  = wrap_inc(head);
  assign head_dn  = wrap_dec(head);
  assign empty    = (count == '0);
  assign full     = (count == CNT_W'(DEPTH));
  assign top_addr = addr_q[head_dn];
  assign top_ptr  = ptr_q[head_dn];

  // The circular write pointer overwrites the oldest pair once full.
  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[head] <= push_addr;
      ptr_q[head]  <= push_ptr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      count <= '0;
    end else if (push) begin
      head <= head_up;
      if (!full) count <= count + 1'b1;
    end else if (pop && !empty) begin
      head  <= head_dn;
      count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/windowed_irf.sv
module windowed_irf #(
  parameter int NUM_WIN     = 4,
  parameter int NUM_SLOTS   = 32,
  parameter int INSN_W      = 32,
  parameter int ADDR_W      = 32,
  parameter int STACK_DEPTH = 8,
  parameter int WORD_OFS    = 2,
  parameter logic [INSN_W-1:0] NOP_INSN = '0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [$clog2(NUM_SLOTS)-1:0] rd_slot,
  output logic [INSN_W-1:0]            rd_insn,
  input  logic                         wr_en,
  input  logic [$clog2(NUM_WIN)-1:0]   wr_win,
  input  logic [$clog2(NUM_SLOTS)-1:0] wr_slot,
  input  logic [INSN_W-1:0]            wr_insn,
  input  logic                         call_req,
  input  logic [ADDR_W-1:0]            call_target,
  input  logic [ADDR_W-1:0]            call_link,
  input  logic                         ret_req,
  output logic                         redirect_valid,
  output logic [ADDR_W-1:0]            redirect_pc,
  output logic [$clog2(NUM_WIN)-1:0]   win_ptr,
  output logic [NUM_WIN-1:0]           win_enable,
  output logic                         stack_overflow,
  output logic                         stack_underflow
);
  import wirf_pkg::*;

  localparam int PTR_W = $clog2(NUM_WIN);

  function automatic logic [PTR_W-1:0] ptr_in_addr(input logic [ADDR_W-1:0] a);
    return a[WORD_OFS +: PTR_W];
  endfunction

  function automatic logic [ADDR_W-1:0] fetch_form(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] m;
    m = '0;
    m[WORD_OFS +: PTR_W] = '1;
    return a & ~m;
  endfunction

  flow_op_e          flow;
  logic              do_call, do_ret, ret_empty;
  logic              stk_empty, stk_full;
  logic [ADDR_W-1:0] stk_addr;
  logic [PTR_W-1:0]  stk_ptr;

  assign flow      = pick_flow(call_req, ret_req);
  assign do_call   = (flow == FLOW_CALL);
  assign do_ret    = (flow == FLOW_RET) && !stk_empty;
  assign ret_empty = (flow == FLOW_RET) && stk_empty;

  wirf_link_stack #(.DEPTH(STACK_DEPTH), .AW(ADDR_W), .PW(PTR_W)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (do_call),
    .pop      (do_ret),
    .push_addr(call_link),
    .push_ptr (win_ptr),
    .top_addr (stk_addr),
    .top_ptr  (stk_ptr),
    .empty    (stk_empty),
    .full     (stk_full)
  );

  wirf_window_bank #(.NWIN(NUM_WIN), .NSLOT(NUM_SLOTS), .IW(INSN_W), .NOP_WORD(NOP_INSN)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_win (wr_win),
    .wr_slot(wr_slot),
    .wr_data(wr_insn),
    .act_win(win_ptr),
    .rd_slot(rd_slot),
    .rd_data(rd_insn),
    .win_en (win_enable)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_ptr         <= '0;
      redirect_valid  <= 1'b0;
      redirect_pc     <= '0;
      stack_overflow  <= 1'b0;
      stack_underflow <= 1'b0;
    end else begin
      redirect_valid <= do_call || do_ret;
      if (do_call) begin
        win_ptr     <= ptr_in_addr(call_target);
        redirect_pc <= fetch_form(call_target);
        if (stk_full) stack_overflow <= 1'b1;
      end else if (do_ret) begin
        win_ptr     <= stk_ptr;
        redirect_pc <= stk_addr;
      end
      if (ret_empty) stack_underflow <= 1'b1;
    end
  end
endmodule

// File: rtl/wirf_checker.sv
module wirf_checker #(
  parameter int NUM_WIN  = 4,
  parameter int ADDR_W   = 32,
  parameter int WORD_OFS = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       call_req,
  input logic                       ret_req,
  input logic [ADDR_W-1:0]          call_target,
  input logic                       stk_empty,
  input logic                       redirect_valid,
  input logic [ADDR_W-1:0]          redirect_pc,
  input logic [$clog2(NUM_WIN)-1:0] win_ptr,
  input logic [NUM_WIN-1:0]         win_enable,
  input logic                       stack_overflow,
  input logic                       stack_underflow
);
  localparam int PW = $clog2(NUM_WIN);

  assert_one_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(win_enable) == 1 && win_enable[win_ptr]);

  assert_call_loads_ptr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |=> win_ptr == $past(call_target[WORD_OFS +: PW]));

  assert_call_redirect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |=> redirect_valid && redirect_pc[WORD_OFS +: PW] == '0);

  assert_call_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && ret_req) |=> redirect_pc == ($past(call_target) & ~(ADDR_W'(NUM_WIN - 1) << WORD_OFS)));

  assert_overflow_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stack_overflow |=> stack_overflow);

  assert_empty_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !call_req && stk_empty) |=> $stable(win_ptr) && !redirect_valid && stack_underflow);

  assert_underflow_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stack_underflow |=> stack_underflow);
endmodule

bind windowed_irf wirf_checker #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .WORD_OFS(WORD_OFS)) u_wirf_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .call_req       (call_req),
  .ret_req        (ret_req),
  .call_target    (call_target),
  .stk_empty      (stk_empty),
  .redirect_valid (redirect_valid),
  .redirect_pc    (redirect_pc),
  .win_ptr        (win_ptr),
  .win_enable     (win_enable),
  .stack_overflow (stack_overflow),
  .stack_underflow(stack_underflow)
);

// File: tb/windowed_irf_test.sv
`timescale 1ns/1ps
module windowed_irf_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  rd_slot = '0;
  logic [31:0] rd_insn;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_win = '0;
  logic [4:0]  wr_slot = '0;
  logic [31:0] wr_insn = '0;
  logic        call_req = 1'b0;
  logic [31:0] call_target = '0;
  logic [31:0] call_link = '0;
  logic        ret_req = 1'b0;
  logic        redirect_valid;
  logic [31:0] redirect_pc;
  logic [1:0]  win_ptr;
  logic [3:0]  win_enable;
  logic        stack_overflow, stack_underflow;

  windowed_irf uut (
    .clk(clk), .rst_n(rst_n), .rd_slot(rd_slot), .rd_insn(rd_insn),
    .wr_en(wr_en), .wr_win(wr_win), .wr_slot(wr_slot), .wr_insn(wr_insn),
    .call_req(call_req), .call_target(call_target), .call_link(call_link),
    .ret_req(ret_req), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .win_ptr(win_ptr), .win_enable(win_enable),
    .stack_overflow(stack_overflow), .stack_underflow(stack_underflow)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference model state
  logic [31:0] m_mem [4][32];
  logic [1:0]  m_ptr;
  logic [31:0] m_sra [8];
  logic [1:0]  m_sp  [8];
  int          m_cnt;
  logic        m_rv, m_ovf, m_unf;
  logic [31:0] m_pc;

  function automatic logic [1:0] bits_ptr(input logic [31:0] a);
    return a[3:2];
  endfunction

  function automatic logic [31:0] bits_fetch(input logic [31:0] a);
    return {a[31:4], 2'b00, a[1:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int w = 0; w < 4; w++)
      for (int s = 0; s < 32; s++) m_mem[w][s] = 32'h0;
    m_ptr = 0; m_cnt = 0; m_rv = 0; m_ovf = 0; m_unf = 0; m_pc = 0;
  endtask

  task automatic model_edge();
    if (wr_en) m_mem[wr_win][wr_slot] = wr_insn;
    if (call_req) begin
      if (m_cnt == 8) begin
        for (int i = 0; i < 7; i++) begin m_sra[i] = m_sra[i+1]; m_sp[i] = m_sp[i+1]; end
        m_sra[7] = call_link; m_sp[7] = m_ptr; m_ovf = 1;
      end else begin
        m_sra[m_cnt] = call_link; m_sp[m_cnt] = m_ptr; m_cnt++;
      end
      m_ptr = bits_ptr(call_target); m_pc = bits_fetch(call_target); m_rv = 1;
    end else if (ret_req) begin
      if (m_cnt == 0) begin m_unf = 1; m_rv = 0; end
      else begin m_cnt--; m_ptr = m_sp[m_cnt]; m_pc = m_sra[m_cnt]; m_rv = 1; end
    end else m_rv = 0;
  endtask

  task automatic compare_all(input string tag);
    check({tag, " R8 rd_insn"}, rd_insn, m_mem[m_ptr][rd_slot]);
    check({tag, " R2 win_ptr"}, {30'd0, win_ptr}, {30'd0, m_ptr});
    check({tag, " R7 win_enable"}, {28'd0, win_enable}, 32'(4'b0001 << m_ptr));
    check({tag, " R4 redirect_valid"}, {31'd0, redirect_valid}, {31'd0, m_rv});
    if (m_rv) check({tag, " R3 redirect_pc"}, redirect_pc, m_pc);
    check({tag, " R5 overflow"}, {31'd0, stack_overflow}, {31'd0, m_ovf});
    check({tag, " R6 underflow"}, {31'd0, stack_underflow}, {31'd0, m_unf});
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all(tag);
    wr_en = 0; call_req = 0; ret_req = 0;
  endtask

  task automatic do_call(input logic [31:0] tgt, input logic [31:0] lnk, input string tag);
    call_req = 1; call_target = tgt; call_link = lnk; step(tag);
  endtask

  task automatic do_ret(input string tag);
    ret_req = 1; step(tag);
  endtask

  task automatic do_write(input logic [1:0] w, input logic [4:0] s, input logic [31:0] d, input string tag);
    wr_en = 1; wr_win = w; wr_slot = s; wr_insn = d; step(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20061023));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state, every slot of window 0 reads nop
    check("R1 win_ptr", {30'd0, win_ptr}, 32'd0);
    check("R1 win_enable", {28'd0, win_enable}, 32'h1);
    check("R1 flags", {30'd0, stack_overflow, stack_underflow}, 32'd0);
    check("R1 redirect_valid", {31'd0, redirect_valid}, 32'd0);
    for (int s = 0; s < 32; s++) begin
      rd_slot = 5'(s); #0.1;
      check("R1 nop read", rd_insn, 32'h0);
    end

    // R8: write inactive window 2 slot 7, read unchanged, then enter window 2
    rd_slot = 5'd7;
    do_write(2'd2, 5'd7, 32'hCAFE_0007, "R8 inactive write");
    check("R8 isolation", rd_insn, 32'h0);
    do_write(2'd0, 5'd7, 32'h1111_0000, "R8 active write");
    check("R8 active", rd_insn, 32'h1111_0000);

    // R6: return on empty stack
    do_ret("R6 empty return");
    check("R6 ptr kept", {30'd0, win_ptr}, 32'd0);

    // R2 R3: call into window 2 with target bits [3:2]=2
    do_call(32'h0040_1238, 32'h0000_0100, "R2 call");
    check("R2 new window read", rd_insn, 32'hCAFE_0007);
    check("R3 masked pc", redirect_pc, 32'h0040_1230);

    // R4: return restores window 0 and link
    do_ret("R4 return");
    check("R4 restored ptr", {30'd0, win_ptr}, 32'd0);
    check("R4 link pc", redirect_pc, 32'h0000_0100);

    // R9: both strobes, call wins
    call_req = 1; ret_req = 1; call_target = 32'h0000_2004; call_link = 32'h0000_0200;
    step("R9 both strobes");
    check("R9 ptr", {30'd0, win_ptr}, 32'd1);
    do_ret("R9 stack kept");
    check("R9 link pop", redirect_pc, 32'h0000_0200);

    // R5: nine nested calls overflow, oldest dropped
    for (int i = 0; i < 9; i++)
      do_call(32'h1000_0000 + 32'(i << 2) + 32'(i << 8), 32'h2000_0000 + 32'(i), "R5 nest");
    check("R5 overflow set", {31'd0, stack_overflow}, 32'd1);
    for (int i = 0; i < 8; i++) do_ret("R5 unwind");
    check("R5 newest kept last link", redirect_pc, 32'h2000_0001);
    do_ret("R6 drained");
    check("R6 underflow after drop", {31'd0, stack_underflow}, 32'd1);

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      rd_slot = 5'($urandom);
      if ($urandom_range(0, 9) < 4) begin
        wr_en = 1; wr_win = 2'($urandom); wr_slot = 5'($urandom); wr_insn = $urandom;
      end
      if (r < 25) begin call_req = 1; call_target = $urandom; call_link = $urandom; end
      if (r >= 20 && r < 50) ret_req = 1;
      step("RND");
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule